// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This peripheral guards a host against software that stops making progress. Software writes a reload value into a 16-bit tick counter and sets the run bit in the control register. From then on the counter counts down by one on every coarse tick. A tick is derived from the system clock by a parameterised prescaler, and by default it lasts 128 ms. Each write to the count register both sets and refreshes the countdown. Reading the count register returns the ticks that are left, and reading the control register tells software whether the timer is running.

If the early-warning bit is set, the block flags a cause bit pair in its status register and raises a level non-maskable interrupt request once the remaining count falls to the lead threshold. The lead threshold is a fixed 9 s, which is 70 ticks. Refreshing the count while the timer runs withdraws that request. If the count reaches zero, the timer stops. When the expiry-action bit is set, it also emits a reset-request pulse of fixed length.

The block sits on a simple single-cycle register bus with halfword data and per-byte lane enables. Register reads are combinational from the address.

Top module: `wdt_top`

## Requirements
- R1: After reset the control register (offset 0x72) reads 0x00, the count register (offset 0x70) reads 0xFFFF, the status register (offset 0x6E) reads 0x00, and both nmi_req and rst_req are low.
- R2: A write to offset 0x70 loads the countdown, and a read of offset 0x70 returns the current remaining tick count.
- R3: While control bit 0 is 1, the count drops by one every CLK_PER_TICK clocks. The first drop comes CLK_PER_TICK clocks after the write that set bit 0 or after the last count write.
- R4: While control bit 0 is 0, the count holds its value, and control reads back the last 8-bit value written to it.
- R5: Writing back control with only bit 0 cleared stops the countdown and leaves every other control bit as it was.
- R6: With control bit 2 set, the tick that brings the count to the lead threshold (70 ticks by default) or below sets the status register to 0x06, and nmi_req then stays high. With bit 2 clear, the status stays 0x00.
- R7: A count write while bit 0 is 1 clears the status to 0x00 and drops nmi_req on the next cycle. A count write while bit 0 is 0 leaves the status unchanged.
- R8: The tick taken at a count of 1 or 0 leaves the count at 0 and clears control bit 0. If control bit 7 is set, rst_req is then high for exactly RST_CYCLES clocks, starting with that edge.
- R9: If control bit 7 is clear at expiry, rst_req stays low.
- R10: Byte enable bit 0 selects data bits 7:0 and byte enable bit 1 selects bits 15:8. In a count write, a lane that is not enabled keeps its old count byte, and control only takes lane 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr, combinational |
| nmi_req | output | 1 | Early-warning interrupt request, level |
| rst_req | output | 1 | System reset request pulse |

## Verification
A wrong prescaler phase or count register shows up on the first count read after one tick period. It appears as a remaining count that is off by one, and in the same tick window rst_req moves to a different cycle. A stale or wrongly set status register shows at once on nmi_req and at the status offset, and the reload and stop tests expose the clear rules within one cycle of the write. A control bit that is lost on stop or expiry reads back wrong on the next control read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DATA_W = 16;
    localparam int BE_W   = DATA_W / 8;
    localparam int ADDR_W = 8;

    // Register offsets are software-visible and therefore fixed.
    localparam logic [ADDR_W-1:0] OFS_CAUSE = 8'h6E;
    localparam logic [ADDR_W-1:0] OFS_COUNT = 8'h70;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 8'h72;

    // Control bit positions
    localparam int CTRL_RUN   = 0;
    localparam int CTRL_EARLY = 2;
    localparam int CTRL_RST   = 7;

    // Value of the cause register once the early warning has fired
    localparam logic [7:0] CAUSE_WDT = 8'h06;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CAUSE,
        SEL_COUNT,
        SEL_CTRL
    } reg_sel_e;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            OFS_CAUSE: s = SEL_CAUSE;
            OFS_COUNT: s = SEL_COUNT;
            OFS_CTRL:  s = SEL_CTRL;
            default:   s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              expire,
    input  logic [DATA_W-1:0] count_q,
    input  logic [7:0]        cause_q,
    output logic [7:0]        ctrl_q,
    output logic              load,
    output logic [DATA_W-1:0] load_val
);
    typedef struct packed {
        logic [7:0] ctrl;
    } regs_st_t;

    regs_st_t st_d, st_q;
    reg_sel_e sel;
    logic     wr_ctrl;

    assign sel     = decode_addr(bus_addr);
    assign load    = bus_req & bus_we & (sel == SEL_COUNT) & (|bus_be);
    assign wr_ctrl = bus_req & bus_we & (sel == SEL_CTRL) & bus_be[0];

    // Merge enabled byte lanes with the live count
    for (genvar b = 0; b < BE_W; b++) begin : g_lane
        assign load_val[b*8 +: 8] = bus_be[b] ? bus_wdata[b*8 +: 8] : count_q[b*8 +: 8];
    end

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            st_d.ctrl = bus_wdata[7:0];
        end
        // Expiry wins over a write in the same cycle
        if (expire) begin
            st_d.ctrl[CTRL_RUN] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_q = st_q.ctrl;

    always_comb begin
        case (sel)
            SEL_CAUSE: bus_rdata = {{(DATA_W-8){1'b0}}, cause_q};
            SEL_COUNT: bus_rdata = count_q;
            SEL_CTRL:  bus_rdata = {{(DATA_W-8){1'b0}}, st_q.ctrl};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int DIV = 6_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_st_t;

    pre_st_t st_d, st_q;

    assign tick = run & (st_q.cnt == LAST);

    always_comb begin
        st_d = st_q;
        if (!run || restart || tick) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int CNT_W      = 16,
    parameter int LEAD_TICKS = 70,
    parameter int RST_CYCLES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             early_en,
    input  logic             reset_en,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count_q,
    output logic [7:0]       cause_q,
    output logic             expire,
    output logic             nmi_req,
    output logic             rst_req
);
    import wdt_pkg::CAUSE_WDT;

    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);
    localparam logic [CNT_W-1:0] LEAD_CNT = CNT_W'(LEAD_TICKS);
    localparam logic [RW-1:0]    PULSE    = RW'(RST_CYCLES);

    typedef struct packed {
        logic [CNT_W-1:0] count;
        logic [7:0]       cause;
        logic [RW-1:0]    rst_cnt;
    } core_st_t;

    core_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (st_q.rst_cnt != '0) begin
            st_d.rst_cnt = st_q.rst_cnt - 1'b1;
        end
        if (load) begin
            st_d.count = load_val;
            if (run) begin
                st_d.cause = '0;
            end
        end else if (tick) begin
            if (st_q.count <= ONE) begin
                st_d.count = '0;
                expire     = 1'b1;
                if (reset_en) begin
                    st_d.rst_cnt = PULSE;
                end
            end else begin
                st_d.count = st_q.count - 1'b1;
            end
            if (early_en && (st_d.count <= LEAD_CNT)) begin
                st_d.cause = CAUSE_WDT;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.count   <= '1;
            st_q.cause   <= '0;
            st_q.rst_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_q = st_q.count;
    assign cause_q = st_q.cause;
    assign nmi_req = |st_q.cause;
    assign rst_req = (st_q.rst_cnt != '0);
endmodule

// File: rtl/wdt_top.sv
module wdt_top #(
    parameter int CLK_PER_TICK = 6_400_000,
    parameter int TICK_MS      = 128,
    parameter int LEAD_MS      = 9000,
    parameter int RST_CYCLES   = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_req,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [1:0]  bus_be,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        nmi_req,
    output logic        rst_req
);
    import wdt_pkg::*;

    localparam int LEAD_TICKS = LEAD_MS / TICK_MS;

    logic [7:0]        ctrl_q;
    logic [7:0]        cause_q;
    logic [DATA_W-1:0] count_q;
    logic [DATA_W-1:0] load_val;
    logic              load;
    logic              tick;
    logic              expire;
    logic              ctrl_run;

    assign ctrl_run = ctrl_q[CTRL_RUN];

    wdt_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .expire    (expire),
        .count_q   (count_q),
        .cause_q   (cause_q),
        .ctrl_q    (ctrl_q),
        .load      (load),
        .load_val  (load_val)
    );

    wdt_prescaler #(.DIV(CLK_PER_TICK)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_run),
        .restart (load),
        .tick    (tick)
    );

    wdt_core #(
        .CNT_W      (DATA_W),
        .LEAD_TICKS (LEAD_TICKS),
        .RST_CYCLES (RST_CYCLES)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .run      (ctrl_run),
        .early_en (ctrl_q[CTRL_EARLY]),
        .reset_en (ctrl_q[CTRL_RST]),
        .load     (load),
        .load_val (load_val),
        .count_q  (count_q),
        .cause_q  (cause_q),
        .expire   (expire),
        .nmi_req  (nmi_req),
        .rst_req  (rst_req)
    );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             run,
    input logic [CNT_W-1:0] count,
    input logic [7:0]       status,
    input logic             load,
    input logic             nmi_req,
    input logic             rst_req
);
    // R6: only the two cause bits can ever be set
    p_cause_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'hF9) == 8'h00);

    // R7: refresh while running withdraws the early warning
    p_refresh_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (load && run) |=> (status == 8'h00 && !nmi_req));

    // R4: stopped counter keeps its value
    p_hold_stopped_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count));

    // R3: running counter moves by at most one step down
    p_single_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !load) |=> (count == $past(count) ||
                            count == CNT_W'($past(count) - 1'b1) ||
                            count == '0));

    // R8: a reset request only starts with the counter stopped at zero
    p_reset_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> (!run && count == '0));
endmodule

bind wdt_top wdt_checker #(.CNT_W(16)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_run),
    .count   (count_q),
    .status  (cause_q),
    .load    (load),
    .nmi_req (nmi_req),
    .rst_req (rst_req)
);

// File: tb/wdt_top_tb.sv
module wdt_top_tb;
    localparam int DIV  = 4;
    localparam int RSTC = 5;
    localparam int LEAD = 9000 / 128;
    localparam logic [7:0] A_ST = 8'h6E;
    localparam logic [7:0] A_CN = 8'h70;
    localparam logic [7:0] A_CT = 8'h72;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [1:0]  bus_be = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        nmi_req;
    logic        rst_req;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdt_top #(.CLK_PER_TICK(DIV), .RST_CYCLES(RSTC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .nmi_req(nmi_req), .rst_req(rst_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        bus_addr = a; bus_req = 1'b1; bus_we = 1'b0;
        #1;
        d = bus_rdata;
        bus_req = 1'b0;
    endtask

    function automatic int exp_count(input int w, input int m);
        return (m / DIV >= w) ? 0 : w - m / DIV;
    endfunction

    function automatic int exp_status(input bit pre, input int w, input int m);
        int t = m / DIV;
        return (pre && t > 0 && exp_count(w, m) <= LEAD) ? 6 : 0;
    endfunction

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [15:0] v, c1;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        rd(A_CT, v); check("R1 ctrl", v, 16'h0000);
        rd(A_CN, v); check("R1 count", v, 16'hFFFF);
        rd(A_ST, v); check("R1 status", v, 16'h0000);
        check("R1 nmi", nmi_req, 0);
        check("R1 rst", rst_req, 0);

        // R10 lane enables, R2 readback (stopped)
        wr(A_CN, 16'h1234, 2'b11);
        rd(A_CN, v); check("R2 load", v, 16'h1234);
        wr(A_CN, 16'hAB00, 2'b10);
        rd(A_CN, v); check("R10 upper lane", v, 16'hAB34);
        wr(A_CN, 16'h55CD, 2'b01);
        rd(A_CN, v); check("R10 lower lane", v, 16'hABCD);
        wr(A_CT, 16'hFF84, 2'b10);
        rd(A_CT, v); check("R10 ctrl lane1 ignored", v, 16'h0000);
        wr(A_CT, 16'h0084, 2'b01);
        rd(A_CT, v); check("R4 ctrl readback", v, 16'h0084);
        repeat (3 * DIV) @(negedge clk);
        rd(A_CN, v); check("R4 hold stopped", v, 16'hABCD);

        // R6 early warning threshold crossing
        wr(A_CT, 16'h0085, 2'b01);
        wr(A_CN, 16'(LEAD + 2), 2'b11);
        repeat (2 * DIV - 1) @(negedge clk);
        rd(A_ST, v); check("R6 before lead", v, 16'h0000);
        check("R6 nmi before lead", nmi_req, 0);
        @(negedge clk);
        rd(A_ST, v); check("R6 at lead", v, 16'h0006);
        check("R6 nmi at lead", nmi_req, 1);
        rd(A_CN, v); check("R3 count at lead", v, 16'(LEAD));

        // R7 refresh while running clears
        wr(A_CN, 16'd200, 2'b11);
        rd(A_ST, v); check("R7 refresh clears", v, 16'h0000);
        check("R7 nmi dropped", nmi_req, 0);

        // R6 disabled early warning
        wr(A_CT, 16'h0081, 2'b01);
        wr(A_CN, 16'(LEAD + 2), 2'b11);
        repeat (3 * DIV) @(negedge clk);
        rd(A_ST, v); check("R6 early off", v, 16'h0000);
        check("R6 nmi early off", nmi_req, 0);

        // R7 write while stopped leaves status
        wr(A_CT, 16'h0085, 2'b01);
        wr(A_CN, 16'(LEAD + 1), 2'b11);
        repeat (DIV) @(negedge clk);
        rd(A_ST, v); check("R6 set again", v, 16'h0006);
        wr(A_CT, 16'h0004, 2'b01);
        wr(A_CN, 16'd500, 2'b11);
        rd(A_ST, v); check("R7 stopped keeps status", v, 16'h0006);
        check("R7 stopped keeps nmi", nmi_req, 1);
        rd(A_CN, v); check("R2 stopped load", v, 16'd500);

        // R8 expiry with reset action
        wr(A_CT, 16'h0085, 2'b01);
        wr(A_CN, 16'd3, 2'b11);
        repeat (3 * DIV - 1) @(negedge clk);
        check("R8 rst before expiry", rst_req, 0);
        rd(A_CN, v); check("R8 count before expiry", v, 16'd1);
        @(negedge clk);
        rd(A_CN, v); check("R8 count expired", v, 16'd0);
        rd(A_CT, v); check("R8 run cleared", v, 16'h0084);
        for (int i = 0; i < RSTC; i++) begin
            check("R8 rst pulse high", rst_req, 1);
            @(negedge clk);
        end
        check("R8 rst pulse end", rst_req, 0);
        rd(A_CN, v); check("R8 stays stopped", v, 16'd0);

        // R9 expiry without reset action
        wr(A_CT, 16'h0001, 2'b01);
        wr(A_CN, 16'd2, 2'b11);
        for (int i = 0; i < 2 * DIV + RSTC + 2; i++) begin
            @(negedge clk);
            if (rst_req !== 1'b0) check("R9 no rst", rst_req, 0);
        end
        check("R9 no rst", rst_req, 0);
        rd(A_CT, v); check("R9 run cleared", v, 16'h0000);

        // Random countdowns: R3, R6, R5, R4
        for (int it = 0; it < 14; it++) begin
            bit pre;
            int w, m;
            pre = 1'($urandom_range(0, 1));
            w = int'($urandom_range(60, 100));
            m = int'($urandom_range(0, w * DIV - 1));
            wr(A_CT, pre ? 16'h0085 : 16'h0081, 2'b01);
            wr(A_CN, 16'(w), 2'b11);
            repeat (m) @(negedge clk);
            rd(A_CN, v); check("R3 random count", v, 32'(exp_count(w, m)));
            rd(A_ST, v); check("R6 random status", v, 32'(exp_status(pre, w, m)));
            check("R6 random nmi", nmi_req, exp_status(pre, w, m) != 0);
            rd(A_CT, v);
            wr(A_CT, v & 16'h00FE, 2'b01);
            rd(A_CT, v); check("R5 stop keeps bits", v, pre ? 16'h0084 : 16'h0080);
            rd(A_CN, c1);
            repeat (2 * DIV) @(negedge clk);
            rd(A_CN, v); check("R4 stopped stable", v, c1);
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule